// File: doc/BRIEF.md
# Cycle-Stamped Register Write Scheduler

This block sits between a processor bus and the register file of a sound engine. It counts processor cycles. Each write to the data port is stored in a FIFO together with the register currently selected and the cycle count at the moment of the write. A write to the address port changes the selection at once and is never queued.

The sound engine raises a sample-advance request once per audio sample. The scheduler then moves its sample window forward by a fixed number of processor cycles. It releases, oldest first, every queued write stamped at or before the new window end. The result is that register changes land at the sample where the processor made them. A flush request releases the whole queue whatever the stamps. A sync input realigns the cycle counter and the window start to a given cycle. Released writes leave the block as a register/value pulse stream, at most one per clock.

Top module: `reg_write_sched`

## Requirements
- R1: After reset, the queue is empty and `outValid`, `busy`, `overflow`, `curCycle`, `selReg` and `selCycle` are all zero. The sample-window start is also zero.
- R2: `curCycle` increments by one on each clock where `cycleAdv` is high. When `syncEn` is high, `curCycle` loads `syncValue` instead, and the increment is skipped.
- R3: An address-port write (`portWrEn` high, `portIsData` low) loads `selReg` with the low `SEL_W` bits of `portData`. It loads `selCycle` with the value `curCycle` held at that clock. It queues nothing and releases nothing.
- R4: A data-port write (`portWrEn` and `portIsData` high) queues the triple {`curCycle`, `selReg`, `portData`}, using the values held at that clock.
- R5: A sample advance accepted while idle sets the window end to start + `CYC_PER_SAMPLE` and moves the start to that end. `CYC_PER_SAMPLE` is (`PSG_CLK_HZ` × 4) / `SAMPLE_HZ` with integer division, which is 181 by default. Entries are then released while the head stamp is less than or equal to the end. Draining stops at the first entry with a later stamp.
- R6: At most one entry is released per clock. The entry appears on `outReg`/`outData`, with `outValid` high for one clock, on the clock after the release decision. `busy` rises on the clock after an accepted request. It falls one clock after the last release, or one clock after the request if nothing qualifies.
- R7: A flush request accepted while idle releases every queued entry, whatever its stamp. When flush and sample advance arrive together, the flush wins and the window does not move.
- R8: `syncEn` also loads the sample-window start with `syncValue`. This overrides any move of the start on the same clock.
- R9: A data write that arrives while the queue holds `DEPTH` entries is dropped. It sets `overflow`, which stays high until reset.
- R10: Sample-advance and flush requests that arrive while `busy` is high are ignored and do not move the window.
- R11: Entries are released in exactly the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cycleAdv | input | 1 | Advance the processor cycle count by one |
| syncEn | input | 1 | Load cycle count and window start from `syncValue` |
| syncValue | input | CYC_W | Value loaded on sync |
| portWrEn | input | 1 | Bus write strobe |
| portIsData | input | 1 | 1 = data port, 0 = address port |
| portData | input | DATA_W | Bus write value |
| sampleAdv | input | 1 | Request to close the next sample window |
| flushReq | input | 1 | Request to release every queued write |
| outValid | output | 1 | Released write present this clock |
| outReg | output | SEL_W | Register index of the released write |
| outData | output | DATA_W | Value of the released write |
| busy | output | 1 | Draining in progress |
| overflow | output | 1 | Sticky: a data write was dropped |
| curCycle | output | CYC_W | Current processor cycle count |
| selReg | output | SEL_W | Currently selected register |
| selCycle | output | CYC_W | Cycle at which the last selection was made |

## Verification
The assertions assume that `portWrEn` is the only bus strobe, so one clock carries either an address write or a data write, never both. They also assume requests are single-clock pulses that the scheduler may ignore while busy. The bench drives every input from a pseudo-random sequence that keeps to these rules. It still lets requests collide with an active drain, with a full queue and with sync, so that the ignore and priority rules are exercised. Directed phases place stamps exactly on and one past a window end, fill the queue past its depth, and realign the counters with sync.

// File: rtl/sched_pkg.sv
package sched_pkg;

  // Strobes issued by the control to the datapath each clock.
  typedef struct packed {
    logic push;   // store the incoming data write
    logic drop;   // data write refused, queue full
    logic pop;    // release the head entry
  } schedStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_DRAINWIN = 2'd1,
    ST_DRAINALL = 2'd2
  } schedState_t;

endpackage

// File: rtl/sched_dp.sv
module sched_dp
  import sched_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int CYC_W  = 32,
  parameter int SEL_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  schedStrobe_t      strb,
  input  logic              cycleAdv,
  input  logic              syncEn,
  input  logic [CYC_W-1:0]  syncValue,
  input  logic              portWrEn,
  input  logic              portIsData,
  input  logic [DATA_W-1:0] portData,
  output logic [CYC_W-1:0]  headCycle,
  output logic              empty,
  output logic              full,
  output logic              outValid,
  output logic [SEL_W-1:0]  outReg,
  output logic [DATA_W-1:0] outData,
  output logic              overflow,
  output logic [CYC_W-1:0]  curCycle,
  output logic [SEL_W-1:0]  selReg,
  output logic [CYC_W-1:0]  selCycle
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CYC_W-1:0]  cycMem [DEPTH];
  logic [SEL_W-1:0]  selMem [DEPTH];
  logic [DATA_W-1:0] datMem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              addrWr;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign addrWr    = portWrEn && !portIsData;
  assign empty     = (count == '0);
  assign full      = (count == FULL_CNT);
  assign headCycle = cycMem[rdPtr];

  // Processor cycle counter, sync has priority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         curCycle <= '0;
    else if (syncEn)   curCycle <= syncValue;
    else if (cycleAdv) curCycle <= curCycle + 1'b1;
  end

  // Register select and the cycle it was made on
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg   <= '0;
      selCycle <= '0;
    end else if (addrWr) begin
      selReg   <= portData[SEL_W-1:0];
      selCycle <= curCycle;
    end
  end

  // Queue storage, one slot per generated lane
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (strb.push && (wrPtr == PTR_W'(g))) begin
        cycMem[g] <= curCycle;
        selMem[g] <= selReg;
        datMem[g] <= portData;
      end
    end
  end

  // Pointers and occupancy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrPtr <= bumpPtr(wrPtr);
      if (strb.pop)  rdPtr <= bumpPtr(rdPtr);
      case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // Release stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outReg   <= '0;
      outData  <= '0;
    end else begin
      outValid <= strb.pop;
      if (strb.pop) begin
        outReg  <= selMem[rdPtr];
        outData <= datMem[rdPtr];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          overflow <= 1'b0;
    else if (strb.drop) overflow <= 1'b1;
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow) else $error("overflow cleared"); // R9

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT) else $error("count above depth"); // R9

  AST_OUT_AFTER_POP: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(strb.pop)) else $error("release without pop"); // R6

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !addrWr |=> $stable(selReg)) else $error("select moved"); // R3

endmodule

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import sched_pkg::*;
#(
  parameter int CYC_W = 32,
  parameter logic [CYC_W-1:0] CYC_PER_SAMPLE = 181
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleAdv,
  input  logic             flushReq,
  input  logic             syncEn,
  input  logic [CYC_W-1:0] syncValue,
  input  logic             portWrEn,
  input  logic             portIsData,
  input  logic             empty,
  input  logic             full,
  input  logic [CYC_W-1:0] headCycle,
  output schedStrobe_t     strb,
  output logic             busy
);

  schedState_t      state;
  logic [CYC_W-1:0] winStart;
  logic [CYC_W-1:0] winEnd;
  logic             dataWr;
  logic             headDue;
  logic             takeFlush;
  logic             takeSample;

  assign dataWr     = portWrEn && portIsData;
  assign headDue    = (state == ST_DRAINALL) || (headCycle <= winEnd);
  assign takeFlush  = (state == ST_IDLE) && flushReq;
  assign takeSample = (state == ST_IDLE) && !flushReq && sampleAdv;
  assign busy       = (state != ST_IDLE);

  always_comb begin
    strb.push = dataWr && !full;
    strb.drop = dataWr && full;
    strb.pop  = busy && !empty && headDue;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (takeFlush)       state <= ST_DRAINALL;
          else if (takeSample) state <= ST_DRAINWIN;
        end
        ST_DRAINWIN, ST_DRAINALL: begin
          if (!strb.pop) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Sample window: end is computed from the start before any sync override
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winStart <= '0;
      winEnd   <= '0;
    end else begin
      if (takeSample) winEnd <= winStart + CYC_PER_SAMPLE;
      if (syncEn)          winStart <= syncValue;
      else if (takeSample) winStart <= winStart + CYC_PER_SAMPLE;
    end
  end

  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> !full) else $error("push into full queue"); // R9

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> !empty) else $error("pop from empty queue"); // R6

  AST_BUSY_ON_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (sampleAdv || flushReq)) |=> busy) else $error("request not taken"); // R6

  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !syncEn) |=> $stable(winStart)) else $error("window moved while busy"); // R10

  AST_STRB_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.push, strb.drop})) else $error("push and drop together"); // R9

endmodule

// File: rtl/reg_write_sched.sv
module reg_write_sched
  import sched_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int CYC_W       = 32,
  parameter int SEL_W       = 4,
  parameter int DATA_W      = 8,
  parameter int PSG_CLK_HZ  = 2_000_000,
  parameter int SAMPLE_HZ   = 44_100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycleAdv,
  input  logic              syncEn,
  input  logic [CYC_W-1:0]  syncValue,
  input  logic              portWrEn,
  input  logic              portIsData,
  input  logic [DATA_W-1:0] portData,
  input  logic              sampleAdv,
  input  logic              flushReq,
  output logic              outValid,
  output logic [SEL_W-1:0]  outReg,
  output logic [DATA_W-1:0] outData,
  output logic              busy,
  output logic              overflow,
  output logic [CYC_W-1:0]  curCycle,
  output logic [SEL_W-1:0]  selReg,
  output logic [CYC_W-1:0]  selCycle
);

  localparam longint CPS_INT = (longint'(PSG_CLK_HZ) * 4) / longint'(SAMPLE_HZ);
  localparam logic [CYC_W-1:0] CYC_PER_SAMPLE = CYC_W'(CPS_INT);

  schedStrobe_t     strb;
  logic [CYC_W-1:0] headCycle;
  logic             empty;
  logic             full;

  sched_ctrl #(
    .CYC_W          (CYC_W),
    .CYC_PER_SAMPLE (CYC_PER_SAMPLE)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleAdv  (sampleAdv),
    .flushReq   (flushReq),
    .syncEn     (syncEn),
    .syncValue  (syncValue),
    .portWrEn   (portWrEn),
    .portIsData (portIsData),
    .empty      (empty),
    .full       (full),
    .headCycle  (headCycle),
    .strb       (strb),
    .busy       (busy)
  );

  sched_dp #(
    .DEPTH  (DEPTH),
    .CYC_W  (CYC_W),
    .SEL_W  (SEL_W),
    .DATA_W (DATA_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cycleAdv   (cycleAdv),
    .syncEn     (syncEn),
    .syncValue  (syncValue),
    .portWrEn   (portWrEn),
    .portIsData (portIsData),
    .portData   (portData),
    .headCycle  (headCycle),
    .empty      (empty),
    .full       (full),
    .outValid   (outValid),
    .outReg     (outReg),
    .outData    (outData),
    .overflow   (overflow),
    .curCycle   (curCycle),
    .selReg     (selReg),
    .selCycle   (selCycle)
  );

endmodule

// File: tb/sim_reg_write_sched.sv
module sim_reg_write_sched;

  localparam int DEPTH = 16;
  localparam int CPS   = (2_000_000 * 4) / 44_100;   // 181

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cycleAdv = 1'b0, syncEn = 1'b0, portWrEn = 1'b0, portIsData = 1'b0;
  logic        sampleAdv = 1'b0, flushReq = 1'b0;
  logic [31:0] syncValue = '0;
  logic [7:0]  portData = '0;
  logic        outValid, busy, overflow;
  logic [3:0]  outReg, selReg;
  logic [7:0]  outData;
  logic [31:0] curCycle, selCycle;

  int checks = 0, fails = 0, relCnt = 0;

  always #10 clk = ~clk;

  reg_write_sched u0 (
    .clk(clk), .rstN(rstN), .cycleAdv(cycleAdv), .syncEn(syncEn), .syncValue(syncValue),
    .portWrEn(portWrEn), .portIsData(portIsData), .portData(portData),
    .sampleAdv(sampleAdv), .flushReq(flushReq), .outValid(outValid), .outReg(outReg),
    .outData(outData), .busy(busy), .overflow(overflow), .curCycle(curCycle),
    .selReg(selReg), .selCycle(selCycle)
  );

  // ---------------- behavioural reference ----------------
  typedef struct { int unsigned cyc; int unsigned sel; int unsigned dat; } ent_t;
  ent_t        q[$];
  int unsigned mCycle = 0, mSel = 0, mSelCyc = 0, mStart = 0, mEnd = 0;
  bit          mBusy = 0, mAll = 0, mOv = 0, mOutV = 0;
  int unsigned mOutReg = 0, mOutDat = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete(); mCycle = 0; mSel = 0; mSelCyc = 0; mStart = 0; mEnd = 0;
      mBusy = 0; mAll = 0; mOv = 0; mOutV = 0;
    end else begin
      bit doPop;
      ent_t e;
      doPop = mBusy && q.size() > 0 && (mAll || q[0].cyc <= mEnd);
      mOutV = doPop;
      if (doPop) begin
        mOutReg = q[0].sel; mOutDat = q[0].dat; void'(q.pop_front());
      end
      if (portWrEn && portIsData) begin
        if (q.size() + (doPop ? 1 : 0) >= DEPTH) mOv = 1;
        else begin
          e.cyc = mCycle; e.sel = mSel; e.dat = portData; q.push_back(e);
        end
      end
      if (mBusy) begin
        if (!doPop) mBusy = 0;
      end else if (flushReq) begin
        mBusy = 1; mAll = 1;
      end else if (sampleAdv) begin
        mBusy = 1; mAll = 0; mEnd = mStart + CPS; mStart = mStart + CPS;
      end
      if (syncEn) mStart = syncValue;
      if (portWrEn && !portIsData) begin
        mSel = portData[3:0]; mSelCyc = mCycle;
      end
      if (syncEn) mCycle = syncValue;
      else if (cycleAdv) mCycle = mCycle + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (outValid) relCnt++;
    chk(curCycle == mCycle, "R2/R8 curCycle", curCycle, mCycle);
    chk(selReg == mSel[3:0] && selCycle == mSelCyc, "R3 select", selCycle, mSelCyc);
    chk(outValid == mOutV, "R6 outValid", outValid, mOutV);
    if (outValid && mOutV)
      chk(outReg == mOutReg[3:0] && outData == mOutDat[7:0], "R4/R11 released entry",
          {outReg, outData}, {mOutReg[3:0], mOutDat[7:0]});
    chk(busy == mBusy, "R6/R10 busy", busy, mBusy);
    chk(overflow == mOv, "R9 overflow", overflow, mOv);
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(); @(negedge clk); endtask

  task automatic addrWr(input logic [7:0] v);
    portWrEn = 1; portIsData = 0; portData = v; step(); portWrEn = 0;
  endtask

  task automatic dataWr(input logic [7:0] v);
    portWrEn = 1; portIsData = 1; portData = v; step(); portWrEn = 0; portIsData = 0;
  endtask

  task automatic waitCycle(input int unsigned c);
    while (curCycle < c) step();
  endtask

  task automatic waitIdle();
    while (busy) step();
  endtask

  task automatic sampleReq();
    sampleAdv = 1; step(); sampleAdv = 0; waitIdle(); step();
  endtask

  task automatic flushAll();
    flushReq = 1; step(); flushReq = 0; waitIdle(); step();
  endtask

  task automatic doReset();
    rstN = 0; step(); step(); rstN = 1;
  endtask

  task automatic resetCheck();
    chk(!outValid && !busy && !overflow && curCycle == 0 && selReg == 0 && selCycle == 0,
        "R1 reset state", {outValid, busy, overflow}, 0);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int unsigned lfsr;
    step(); step();
    resetCheck();
    rstN = 1;
    cycleAdv = 1;

    // R3: select with stamp, upper data bits ignored
    waitCycle(5);
    addrWr(8'hF3);
    chk(selReg == 4'd3 && selCycle == 32'd5, "R3 select load", selCycle, 5);
    chk(!busy && !outValid, "R3 nothing queued", busy, 0);

    // R5: stamps around the first window end (181)
    waitCycle(10);  dataWr(8'hA1);
    waitCycle(100); dataWr(8'hB2);
    waitCycle(181); dataWr(8'hC3);
    waitCycle(182); dataWr(8'hD4);
    waitCycle(300); dataWr(8'hE5);
    waitCycle(400);
    relCnt = 0; sampleReq();
    chk(relCnt == 3, "R5 first window inclusive end", relCnt, 3);
    relCnt = 0; sampleReq();
    chk(relCnt == 2, "R5 second window", relCnt, 2);

    // R10: second request during a drain is ignored (window start stays 543)
    waitCycle(450); dataWr(8'h11);
    waitCycle(470);
    relCnt = 0;
    sampleAdv = 1; step(); sampleAdv = 1; step(); sampleAdv = 0;
    waitIdle(); step();
    chk(relCnt == 1, "R10 drain of window 543", relCnt, 1);
    waitCycle(800); dataWr(8'h22);
    relCnt = 0; sampleReq();
    chk(relCnt == 0, "R10 ignored request left window at 724", relCnt, 0);

    // R7: flush releases everything
    dataWr(8'h33); dataWr(8'h44); dataWr(8'h55);
    relCnt = 0; flushAll();
    chk(relCnt == 4, "R7 flush count", relCnt, 4);

    // R8: sync realigns both counters
    syncValue = 32'd10000; syncEn = 1; step(); syncEn = 0;
    chk(curCycle == 32'd10000 || curCycle == 32'd10001, "R8 sync cycle", curCycle, 10000);
    waitCycle(10005); dataWr(8'h66);
    waitCycle(10300); dataWr(8'h77);
    relCnt = 0; sampleReq();
    chk(relCnt == 1, "R8 window from synced start", relCnt, 1);
    relCnt = 0; flushAll();

    // R9: overflow on the write past depth
    for (int i = 0; i < DEPTH + 1; i++) dataWr(8'(i));
    chk(overflow == 1'b1, "R9 overflow set", overflow, 1);
    relCnt = 0; flushAll();
    chk(relCnt == DEPTH, "R9 only depth entries kept", relCnt, DEPTH);
    chk(overflow == 1'b1, "R9 overflow sticky", overflow, 1);

    // R1: reset again, then a pseudo-random mix
    cycleAdv = 0;
    doReset();
    resetCheck();
    lfsr = 32'h1ACE_B00C;
    for (int n = 0; n < 4000; n++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      cycleAdv   = (lfsr[1:0] != 2'b00);
      portWrEn   = (lfsr[4:2] < 3'd3);
      portIsData = (lfsr[6:5] != 2'b00);
      portData   = lfsr[15:8];
      sampleAdv  = (lfsr[22:18] == 5'd0);
      flushReq   = (lfsr[30:24] == 7'd0);
      syncEn     = (lfsr[31:23] == 9'd5);
      syncValue  = {16'd0, lfsr[31:16]};
      step();
    end
    {cycleAdv, portWrEn, portIsData, sampleAdv, flushReq, syncEn} = '0;
    step();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule